// File: doc/BRIEF.md
# Two-Stage Pending Interrupt Controller Core

This core gathers requests from 32 interrupt sources and turns them into two CPU-facing lines: a fast request and a normal request. Every request is first latched in a source-pending register, whatever the mask says. A per-source routing bit sends a source either to the fast line or to the normal path, and a mask bit decides whether the source may be serviced at all.

On the normal path the core does not rank sources itself. It publishes the unmasked, normal-routed pending set as a candidate vector to an external priority tree. The tree answers with a winner index. When nothing is in service, the core latches that winner as a single in-service bit and records its index in an offset register. The normal line stays high while the in-service bit is set. Software clears both pending stages by writing ones, using a small word-addressed register bus.

Top module: `ipc_core`

## Requirements
- R1: A source-pending bit is set on the clock edge after its request input is high, whether or not the source is masked or in service. The pending register reads at byte address 0x00.
- R2: A source-pending bit stays set until software clears it. A write to 0x00 clears exactly the bits written as 1. If a request arrives on the same bit in the same cycle as the clear, the bit stays set.
- R3: After reset, the mask register (0x08) reads 0xFFFFFFFF. Pending, routing, in-service, offset and priority configuration all read 0, and both interrupt outputs are low.
- R4: `cand_o` equals pending AND NOT mask AND NOT routing bit, bit by bit.
- R5: `fast_irq_o` is high while any source has its pending bit set, its mask bit clear and its routing bit (0x04) at 1. A routing bit of 0 keeps the source off the fast line.
- R6: A write to the routing register keeps only the lowest-indexed 1 of the written word, so at most one routing bit is ever set.
- R7: A fast-routed source never sets an in-service bit and never loads the offset register, even when the winner index points at it.
- R8: When no in-service bit is set, `win_valid_i` is high and `cand_o[win_idx_i]` is 1, the in-service register (0x10) becomes one-hot at `win_idx_i` on the next edge. The offset register (0x14) takes the value `win_idx_i` on that same edge, and `norm_irq_o` is high while an in-service bit is set. A winner index that is not a candidate loads nothing.
- R9: While an in-service bit is set, new winner indices are ignored, and the in-service and offset registers keep their values.
- R10: A write to 0x10 clears exactly the in-service bits written as 1. Clearing the set bit drops `norm_irq_o`.
- R11: The priority configuration word at 0x0C is readable and writable in full and drives `prio_cfg_o`.
- R12: Writes to the offset register are ignored. Reads from unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Per-source request levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| cand_o | output | N_SRC | Normal-path candidates sent to the priority tree |
| win_valid_i | input | 1 | The winner index from the tree is valid |
| win_idx_i | input | IDX_W | Winner index chosen by the priority tree |
| prio_cfg_o | output | DW | Priority configuration word sent to the tree |
| fast_irq_o | output | 1 | Fast interrupt request |
| norm_irq_o | output | 1 | Normal interrupt request |

## Verification
The bench drives three distinct request patterns, and each one separates a different part of the logic. First, a masked two-bit pulse on normal-routed sources shows that recording happens independently of the mask. Second, a single fast-routed source, with the winner index aimed at it, separates the fast line from the in-service path. Third, a pair of unmasked normal sources with competing winner indices shows that the first winner holds while later indices are ignored. Clear writes that name both set and unset bits, plus a clear that collides with a live request, distinguish a write-one-to-clear from a plain overwrite.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int DW = 32;
    localparam int AW = 5;

    localparam logic [AW-1:0] A_PEND   = 5'h00;
    localparam logic [AW-1:0] A_ROUTE  = 5'h04;
    localparam logic [AW-1:0] A_MASK   = 5'h08;
    localparam logic [AW-1:0] A_PRIO   = 5'h0C;
    localparam logic [AW-1:0] A_INSERV = 5'h10;
    localparam logic [AW-1:0] A_OFFSET = 5'h14;

    typedef enum logic [2:0] {
        SEL_PEND, SEL_ROUTE, SEL_MASK, SEL_PRIO, SEL_INSERV, SEL_OFFSET, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic          we;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } bus_op_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        case (a)
            A_PEND:   return SEL_PEND;
            A_ROUTE:  return SEL_ROUTE;
            A_MASK:   return SEL_MASK;
            A_PRIO:   return SEL_PRIO;
            A_INSERV: return SEL_INSERV;
            A_OFFSET: return SEL_OFFSET;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ipc_pend.sv
module ipc_pend #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_bits,
    output logic [N_SRC-1:0] pend_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else if (req[i])
                pend_q[i] <= 1'b1;
            else if (clr_en && clr_bits[i])
                pend_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/ipc_cfg_regs.sv
module ipc_cfg_regs
    import ipc_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_op_t          op,
    output logic [N_SRC-1:0] route_q,
    output logic [N_SRC-1:0] mask_q,
    output logic [DW-1:0]    prio_q
);
    logic [N_SRC-1:0] wr_bits;
    logic [N_SRC-1:0] route_d;

    assign wr_bits = op.data[N_SRC-1:0];
    // isolate the lowest set bit: at most one fast-routed source
    assign route_d = wr_bits & (~wr_bits + 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q <= '0;
            mask_q  <= '1;
            prio_q  <= '0;
        end else if (op.we) begin
            case (op.sel)
                SEL_ROUTE: route_q <= route_d;
                SEL_MASK:  mask_q  <= wr_bits;
                SEL_PRIO:  prio_q  <= op.data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ipc_service.sv
module ipc_service #(
    parameter int N_SRC = 32,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] cand,
    input  logic             win_valid,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] clr_bits,
    output logic [N_SRC-1:0] inserv_q,
    output logic [IDX_W-1:0] offset_q
);
    logic [N_SRC-1:0] inserv_d;
    logic [IDX_W-1:0] offset_d;
    logic             take;

    assign take = (inserv_q == '0) && win_valid && cand[win_idx];

    always_comb begin
        inserv_d = clr_en ? (inserv_q & ~clr_bits) : inserv_q;
        offset_d = offset_q;
        if (take) begin
            inserv_d          = '0;
            inserv_d[win_idx] = 1'b1;
            offset_d          = win_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inserv_q <= '0;
            offset_q <= '0;
        end else begin
            inserv_q <= inserv_d;
            offset_q <= offset_d;
        end
    end
endmodule

// File: rtl/ipc_core.sv
module ipc_core
    import ipc_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_req,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic [N_SRC-1:0] cand_o,
    input  logic             win_valid_i,
    input  logic [IDX_W-1:0] win_idx_i,
    output logic [DW-1:0]    prio_cfg_o,
    output logic             fast_irq_o,
    output logic             norm_irq_o
);
    bus_op_t          op;
    logic [N_SRC-1:0] pend_q, route_q, mask_q, inserv_q;
    logic [IDX_W-1:0] offset_q;
    logic [DW-1:0]    prio_q;

    assign op.we   = bus_we;
    assign op.sel  = decode_addr(bus_addr);
    assign op.data = bus_wdata;

    ipc_pend #(.N_SRC(N_SRC)) pend_i (
        .clk(clk), .rst(rst), .req(src_req),
        .clr_en(op.we && op.sel == SEL_PEND),
        .clr_bits(op.data[N_SRC-1:0]),
        .pend_q(pend_q)
    );

    ipc_cfg_regs #(.N_SRC(N_SRC)) cfg_i (
        .clk(clk), .rst(rst), .op(op),
        .route_q(route_q), .mask_q(mask_q), .prio_q(prio_q)
    );

    logic [N_SRC-1:0] live;
    assign live       = pend_q & ~mask_q;
    assign cand_o     = live & ~route_q;
    assign fast_irq_o = |(live & route_q);

    ipc_service #(.N_SRC(N_SRC), .IDX_W(IDX_W)) svc_i (
        .clk(clk), .rst(rst), .cand(cand_o),
        .win_valid(win_valid_i), .win_idx(win_idx_i),
        .clr_en(op.we && op.sel == SEL_INSERV),
        .clr_bits(op.data[N_SRC-1:0]),
        .inserv_q(inserv_q), .offset_q(offset_q)
    );

    assign norm_irq_o = |inserv_q;
    assign prio_cfg_o = prio_q;

    always_comb begin
        case (op.sel)
            SEL_PEND:   bus_rdata = DW'(pend_q);
            SEL_ROUTE:  bus_rdata = DW'(route_q);
            SEL_MASK:   bus_rdata = DW'(mask_q);
            SEL_PRIO:   bus_rdata = prio_q;
            SEL_INSERV: bus_rdata = DW'(inserv_q);
            SEL_OFFSET: bus_rdata = DW'(offset_q);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ipc_core_chk.sv
module ipc_core_chk #(
    parameter int N_SRC = 32,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] src_req,
    input logic [N_SRC-1:0] pend,
    input logic [N_SRC-1:0] route,
    input logic [N_SRC-1:0] inserv,
    input logic [IDX_W-1:0] offset
);
    p_req_sets_pend_r1: assert property (@(posedge clk) disable iff (rst)
        (src_req != '0) |=> ((pend & $past(src_req)) == $past(src_req)));

    p_no_spurious_pend_r2: assert property (@(posedge clk) disable iff (rst)
        (src_req == '0) |=> ((pend & ~$past(pend)) == '0));

    p_route_single_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(route));

    p_inserv_single_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(inserv));

    p_offset_match_r8: assert property (@(posedge clk) disable iff (rst)
        (inserv != '0) |-> inserv[offset]);

    p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (inserv != '0) |=> ((inserv & ~$past(inserv)) == '0));
endmodule

bind ipc_core ipc_core_chk #(.N_SRC(N_SRC), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst), .src_req(src_req), .pend(pend_q),
    .route(route_q), .inserv(inserv_q), .offset(offset_q)
);

// File: tb/ipc_core_tb_top.sv
`timescale 1ns/1ps
module ipc_core_tb_top;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] src_req = '0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] cand_o;
    logic        win_valid_i = 1'b0;
    logic [4:0]  win_idx_i = '0;
    logic [31:0] prio_cfg_o;
    logic        fast_irq_o, norm_irq_o;

    always #2 clk = ~clk;

    ipc_core dut_i (
        .clk(clk), .rst(rst), .src_req(src_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cand_o(cand_o), .win_valid_i(win_valid_i), .win_idx_i(win_idx_i),
        .prio_cfg_o(prio_cfg_o), .fast_irq_o(fast_irq_o), .norm_irq_o(norm_irq_o)
    );

    typedef struct {
        int          sel;   // 0 rdata, 1 fast, 2 normal, 3 cand, 4 prio
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    event  probe_ev;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            @(probe_ev);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = exp_q.pop_front();
                case (it.sel)
                    0: act = bus_rdata;
                    1: act = {31'd0, fast_irq_o};
                    2: act = {31'd0, norm_irq_o};
                    3: act = cand_o;
                    default: act = prio_cfg_o;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        src_req = bits;
        step();
        src_req = '0;
    endtask

    // driver: push the expectation, present the probe, let the monitor sample
    task automatic expect_v(input int sel, input logic [4:0] a,
                            input logic [31:0] e, input string tag);
        item_t it;
        it.sel = sel; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        bus_addr = a;
        -> probe_ev;
        #2;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        step(); step(); step();
        rst = 1'b0;
        step();

        // R3 reset state
        expect_v(0, 5'h08, 32'hFFFF_FFFF, "R3 mask reset");
        expect_v(0, 5'h00, 32'h0, "R3 pending reset");
        expect_v(0, 5'h04, 32'h0, "R3 route reset");
        expect_v(0, 5'h10, 32'h0, "R3 inserv reset");
        expect_v(0, 5'h14, 32'h0, "R3 offset reset");
        expect_v(1, 5'h00, 32'h0, "R3 fast low");
        expect_v(2, 5'h00, 32'h0, "R3 normal low");
        expect_v(4, 5'h00, 32'h0, "R3 prio reset");

        // R1 masked requests still recorded
        pulse(32'h0000_0401);
        expect_v(0, 5'h00, 32'h0000_0401, "R1 masked pending set");
        expect_v(3, 5'h00, 32'h0, "R4 masked not candidate");

        // R2 persistence and write-one-to-clear
        step(); step(); step();
        expect_v(0, 5'h00, 32'h0000_0401, "R2 pending persists");
        wr(5'h00, 32'h0000_0400);
        expect_v(0, 5'h00, 32'h0000_0001, "R2 clear only ones");
        pulse(32'h0000_0020);
        src_req = 32'h0000_0020;
        wr(5'h00, 32'h0000_0020);
        src_req = '0;
        expect_v(0, 5'h00, 32'h0000_0021, "R2 request beats clear");
        wr(5'h00, 32'h0000_0021);
        expect_v(0, 5'h00, 32'h0, "R2 cleared");

        // R6 routing keeps lowest set bit
        wr(5'h04, 32'h0000_0030);
        expect_v(0, 5'h04, 32'h0000_0010, "R6 route lowest kept");

        // R5 / R7 fast path
        wr(5'h08, 32'hFFFF_FFEF);
        expect_v(1, 5'h00, 32'h0, "R5 fast low without pending");
        pulse(32'h0000_0010);
        expect_v(1, 5'h00, 32'h1, "R5 fast high");
        expect_v(3, 5'h00, 32'h0, "R4 fast source not candidate");
        win_valid_i = 1'b1; win_idx_i = 5'd4;
        step();
        win_valid_i = 1'b0;
        expect_v(0, 5'h10, 32'h0, "R7 fast no inserv");
        expect_v(2, 5'h00, 32'h0, "R7 normal stays low");
        wr(5'h00, 32'h0000_0010);
        expect_v(1, 5'h00, 32'h0, "R5 fast drops after clear");
        wr(5'h04, 32'h0);

        // R8 / R9 normal path
        wr(5'h08, 32'hFFFF_F3FF);
        pulse(32'h0000_0C00);
        expect_v(3, 5'h00, 32'h0000_0C00, "R4 candidates");
        win_valid_i = 1'b1; win_idx_i = 5'd5;
        step();
        expect_v(0, 5'h10, 32'h0, "R8 non-candidate index ignored");
        win_idx_i = 5'd11;
        step();
        expect_v(0, 5'h10, 32'h0000_0800, "R8 inserv loaded");
        expect_v(0, 5'h14, 32'd11, "R8 offset loaded");
        expect_v(2, 5'h00, 32'h1, "R8 normal high");
        win_idx_i = 5'd10;
        step();
        win_valid_i = 1'b0;
        expect_v(0, 5'h10, 32'h0000_0800, "R9 inserv held");
        expect_v(0, 5'h14, 32'd11, "R9 offset held");

        // R10 in-service clear
        wr(5'h10, 32'h0000_0400);
        expect_v(0, 5'h10, 32'h0000_0800, "R10 zero bits untouched");
        wr(5'h10, 32'h0000_0800);
        expect_v(0, 5'h10, 32'h0, "R10 inserv cleared");
        expect_v(2, 5'h00, 32'h0, "R10 normal low");
        expect_v(0, 5'h00, 32'h0000_0C00, "R1 pending untouched by service");
        win_valid_i = 1'b1; win_idx_i = 5'd10;
        step();
        win_valid_i = 1'b0;
        expect_v(0, 5'h10, 32'h0000_0400, "R8 next winner");
        expect_v(0, 5'h14, 32'd10, "R8 next offset");

        // R11 priority word
        wr(5'h0C, 32'h001F_FFFF);
        expect_v(0, 5'h0C, 32'h001F_FFFF, "R11 prio readback");
        expect_v(4, 5'h00, 32'h001F_FFFF, "R11 prio output");

        // R12 offset read-only, unmapped reads zero
        wr(5'h14, 32'd5);
        expect_v(0, 5'h14, 32'd10, "R12 offset write ignored");
        expect_v(0, 5'h18, 32'h0, "R12 unmapped reads zero");

        #4;
        done = 1'b1;
        summary();
    end
endmodule